// File: doc/BRIEF.md
# DRBG Command Sequencer

This block sits in front of a deterministic random bit generator. It takes command headers from a single application port and runs each command through its steps. It decodes the operation code, the additional-data length, the flag0 multi-bit boolean and the generate length. When a seed operation needs entropy, the block asks the entropy source for it. For generate commands it drives a cipher stand-in that returns one 128-bit block a fixed number of cycles after each request. It streams the generated words out over a valid/ready port and finishes every command with exactly one status pulse.

The block keeps two quality flags. The first is a FIPS flag that is the inverse of the flag0 value from the last instantiate or reseed. The second is a per-word quality bit that follows the entropy source's own indication for the current seed. If flag0 carries a malformed encoding, the block raises a recoverable alert and sets a sticky status bit. A halt input stops new block requests while it is asserted. The real DRBG arithmetic is replaced by a block counter: the stub turns the counter into a recognisable pattern, so that the order and number of blocks can be checked.

Top module: `drbg_cmd_seq`

## Requirements
- R1: After synchronous reset, cmd_ready is 1 and out_valid, rsp_valid, es_req, fips, recov_alert and flag0_err_sts are all 0.
- R2: Header fields are laid out as follows: operation code in bits [3:0], additional-data word count in [7:4], flag0 in [11:8], generate length in [24:12], and bits [31:25] reserved. The operation codes are 1 for instantiate, 2 for reseed, 3 for generate, 4 for update and 5 for uninstantiate.
- R3: A generate command delivers exactly glen words and then one rsp_valid pulse with rsp_err=0. When glen is 0, it delivers only the status pulse. Every status pulse lasts one cycle and never coincides with out_valid.
- R4: After each header, exactly clen further words are taken on the command port before the command runs. A clen of 12 is accepted.
- R5: An instantiate or reseed with flag0=4'h9 (false) raises es_req and holds it until es_ack. With flag0=4'h6 (true), es_req is never raised.
- R6: fips equals the inverse of the flag0 value from the last accepted instantiate or reseed. Uninstantiate clears it to 0.
- R7: out_fips on each word equals the es_fips value captured with the entropy of the current seed. It is 0 when the seed was taken with flag0 true, and 0 after uninstantiate.
- R8: A flag0 value on instantiate or reseed other than 4'h6 or 4'h9 produces a one-cycle recov_alert, sets flag0_err_sts (which stays set until reset) and returns rsp_err=1. It changes neither fips nor the block counter, and it raises no es_req.
- R9: While halt is 1, no new block is requested, so out_valid stays 0 during a generate that has no block in flight.
- R10: While out_valid=1 and out_ready=0, out_valid, out_data and out_fips hold their values.
- R11: An operation code outside 1..5, or nonzero reserved bits, returns rsp_err=1 and leaves fips and the block counter unchanged.
- R12: Each out_data word is {~c, c, ~c, c} in 32-bit lanes, MSB lane first, where c is a 32-bit block counter. The counter is cleared by instantiate, reseed and uninstantiate and is incremented once for each block.
- R13: An update returns rsp_err=0 and leaves fips and the block counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command word valid |
| cmd_ready | output | 1 | Command word accepted when valid |
| cmd_data | input | 32 | Header or additional-data word |
| es_req | output | 1 | Entropy request, held until acknowledged |
| es_ack | input | 1 | Entropy delivered |
| es_fips | input | 1 | Quality indication sent with the entropy |
| halt | input | 1 | Blocks new cipher requests |
| out_valid | output | 1 | Generated word valid |
| out_ready | input | 1 | Consumer takes the word |
| out_data | output | BLK_W | Generated word |
| out_fips | output | 1 | Quality bit of the word |
| rsp_valid | output | 1 | One-cycle status pulse |
| rsp_err | output | 1 | 1 = error status |
| fips | output | 1 | Current FIPS flag |
| recov_alert | output | 1 | Recoverable alert pulse |
| flag0_err_sts | output | 1 | Sticky malformed-flag0 status |

## Verification
Generate is exercised with lengths 0, 1 and 3, with the consumer accepting every cycle, stalling every third cycle, and stalling for several cycles. These runs separate a wrong word count, a missing or duplicated status, and words that change while stalled. Seed operations cover flag0 true, flag0 false with the entropy-quality bit both high and low, and a malformed flag0. Together they show whether entropy is requested only when needed and whether the two quality flags come from the right source. An unknown code and an update are each followed by a generate, so any disturbance of the block counter shows up in the data pattern.

// File: rtl/dseq_pkg.sv
package dseq_pkg;
  localparam int CMD_W  = 32;
  localparam int GLEN_W = 13;

  localparam logic [3:0] OP_INST   = 4'd1;
  localparam logic [3:0] OP_RESEED = 4'd2;
  localparam logic [3:0] OP_GEN    = 4'd3;
  localparam logic [3:0] OP_UPD    = 4'd4;
  localparam logic [3:0] OP_UNINST = 4'd5;

  localparam logic [3:0] MB_TRUE  = 4'h6;
  localparam logic [3:0] MB_FALSE = 4'h9;

  typedef struct packed {
    logic [6:0]        rsvd;
    logic [GLEN_W-1:0] glen;
    logic [3:0]        flag0;
    logic [3:0]        clen;
    logic [3:0]        op;
  } hdr_t;

  typedef enum logic [2:0] {
    S_IDLE, S_ADATA, S_DISP, S_ENT, S_GEN, S_WAIT, S_OUT
  } st_e;
endpackage

// File: rtl/dseq_hdr_decode.sv
module dseq_hdr_decode
  import dseq_pkg::*;
(
  input  logic [3:0] op,
  input  logic [3:0] flag0,
  input  logic [6:0] rsvd,
  output logic       known,
  output logic       seed_op,
  output logic       is_gen,
  output logic       is_uninst,
  output logic       f0_ok,
  output logic       f0_true
);
  always_comb begin
    known     = (rsvd == '0) && (op >= OP_INST) && (op <= OP_UNINST);
    seed_op   = (op == OP_INST) || (op == OP_RESEED);
    is_gen    = (op == OP_GEN);
    is_uninst = (op == OP_UNINST);
    f0_true   = (flag0 == MB_TRUE);
    f0_ok     = f0_true || (flag0 == MB_FALSE);
  end
endmodule

// File: rtl/dseq_cipher_stub.sv
module dseq_cipher_stub #(
  parameter int LAT   = 4,
  parameter int BLK_W = 128,
  parameter int CTR_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic [CTR_W-1:0] ctr_in,
  output logic             busy,
  output logic             done,
  output logic [BLK_W-1:0] blk
);
  localparam int NL  = BLK_W / CTR_W;
  localparam int CNW = (LAT > 1) ? $clog2(LAT) : 1;

  logic [CNW-1:0]   cnt;
  logic [CTR_W-1:0] ctr_q;
  logic [BLK_W-1:0] pat;

  for (genvar i = 0; i < NL; i++) begin : g_lane
    if (i % 2 == 0) begin : g_even
      assign pat[i*CTR_W +: CTR_W] = ctr_q;
    end else begin : g_odd
      assign pat[i*CTR_W +: CTR_W] = ~ctr_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      cnt   <= '0;
      ctr_q <= '0;
      blk   <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (req) begin
          busy  <= 1'b1;
          cnt   <= CNW'(LAT - 1);
          ctr_q <= ctr_in;
        end
      end else if (cnt == '0) begin
        busy <= 1'b0;
        done <= 1'b1;
        blk  <= pat;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/drbg_cmd_seq.sv
module drbg_cmd_seq
  import dseq_pkg::*;
#(
  parameter int CIPHER_LAT = 4,
  parameter int BLK_W      = 128,
  parameter int CTR_W      = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [CMD_W-1:0] cmd_data,
  output logic             es_req,
  input  logic             es_ack,
  input  logic             es_fips,
  input  logic             halt,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [BLK_W-1:0] out_data,
  output logic             out_fips,
  output logic             rsp_valid,
  output logic             rsp_err,
  output logic             fips,
  output logic             recov_alert,
  output logic             flag0_err_sts
);
  st_e               st;
  hdr_t              in_hdr, hdr_q;
  logic [3:0]        ad_cnt;
  logic [GLEN_W-1:0] remain;
  logic [CTR_W-1:0]  ctr;
  logic              fips_q, seed_fips_q;
  logic              known, seed_op, is_gen, is_uninst, f0_ok, f0_true;
  logic              cipher_req, stub_busy, blk_done;
  logic [BLK_W-1:0]  blk;

  assign in_hdr = cmd_data;

  dseq_hdr_decode u_dec (
    .op(hdr_q.op), .flag0(hdr_q.flag0), .rsvd(hdr_q.rsvd),
    .known(known), .seed_op(seed_op), .is_gen(is_gen), .is_uninst(is_uninst),
    .f0_ok(f0_ok), .f0_true(f0_true)
  );

  assign cipher_req = (st == S_GEN) && (remain != '0) && !halt && !stub_busy;

  dseq_cipher_stub #(.LAT(CIPHER_LAT), .BLK_W(BLK_W), .CTR_W(CTR_W)) u_stub (
    .clk(clk), .rst(rst), .req(cipher_req), .ctr_in(ctr),
    .busy(stub_busy), .done(blk_done), .blk(blk)
  );

  assign cmd_ready = (st == S_IDLE) || (st == S_ADATA);
  assign fips      = fips_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= S_IDLE;
      hdr_q         <= '0;
      ad_cnt        <= '0;
      remain        <= '0;
      ctr           <= '0;
      fips_q        <= 1'b0;
      seed_fips_q   <= 1'b0;
      es_req        <= 1'b0;
      out_valid     <= 1'b0;
      out_data      <= '0;
      out_fips      <= 1'b0;
      rsp_valid     <= 1'b0;
      rsp_err       <= 1'b0;
      recov_alert   <= 1'b0;
      flag0_err_sts <= 1'b0;
    end else begin
      rsp_valid   <= 1'b0;
      recov_alert <= 1'b0;
      unique case (st)
        S_IDLE: if (cmd_valid) begin
          hdr_q  <= in_hdr;
          ad_cnt <= '0;
          st     <= (in_hdr.clen == '0) ? S_DISP : S_ADATA;
        end
        S_ADATA: if (cmd_valid) begin
          ad_cnt <= ad_cnt + 4'd1;
          if (ad_cnt == hdr_q.clen - 4'd1) st <= S_DISP;
        end
        S_DISP: begin
          if (!known) begin
            rsp_valid <= 1'b1;
            rsp_err   <= 1'b1;
            st        <= S_IDLE;
          end else if (seed_op) begin
            if (!f0_ok) begin
              recov_alert   <= 1'b1;
              flag0_err_sts <= 1'b1;
              rsp_valid     <= 1'b1;
              rsp_err       <= 1'b1;
              st            <= S_IDLE;
            end else if (f0_true) begin
              fips_q      <= 1'b0;
              seed_fips_q <= 1'b0;
              ctr         <= '0;
              rsp_valid   <= 1'b1;
              rsp_err     <= 1'b0;
              st          <= S_IDLE;
            end else begin
              es_req <= 1'b1;
              st     <= S_ENT;
            end
          end else if (is_gen) begin
            remain <= hdr_q.glen;
            st     <= S_GEN;
          end else begin
            if (is_uninst) begin
              fips_q      <= 1'b0;
              seed_fips_q <= 1'b0;
              ctr         <= '0;
            end
            rsp_valid <= 1'b1;
            rsp_err   <= 1'b0;
            st        <= S_IDLE;
          end
        end
        S_ENT: if (es_ack) begin
          es_req      <= 1'b0;
          fips_q      <= 1'b1;
          seed_fips_q <= es_fips;
          ctr         <= '0;
          rsp_valid   <= 1'b1;
          rsp_err     <= 1'b0;
          st          <= S_IDLE;
        end
        S_GEN: begin
          if (remain == '0) begin
            rsp_valid <= 1'b1;
            rsp_err   <= 1'b0;
            st        <= S_IDLE;
          end else if (cipher_req) begin
            ctr <= ctr + 1'b1;
            st  <= S_WAIT;
          end
        end
        S_WAIT: if (blk_done) begin
          out_data  <= blk;
          out_fips  <= seed_fips_q;
          out_valid <= 1'b1;
          remain    <= remain - 1'b1;
          st        <= S_OUT;
        end
        S_OUT: if (out_ready) begin
          out_valid <= 1'b0;
          st        <= S_GEN;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dseq_checker.sv
module dseq_checker #(
  parameter int BLK_W = 128
) (
  input logic             clk,
  input logic             rst,
  input logic             es_req,
  input logic             es_ack,
  input logic             out_valid,
  input logic             out_ready,
  input logic [BLK_W-1:0] out_data,
  input logic             out_fips,
  input logic             rsp_valid,
  input logic             recov_alert,
  input logic             flag0_err_sts
);
  a_r10_word_held: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_fips)));

  a_r5_es_req_held: assert property (@(posedge clk) disable iff (rst)
    (es_req && !es_ack) |=> es_req);

  a_r8_alert_sets_sts: assert property (@(posedge clk) disable iff (rst)
    recov_alert |=> flag0_err_sts);

  a_r8_sts_sticky: assert property (@(posedge clk) disable iff (rst)
    flag0_err_sts |=> flag0_err_sts);

  a_r8_alert_pulse: assert property (@(posedge clk) disable iff (rst)
    recov_alert |=> !recov_alert);

  a_r3_single_status: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  a_r3_status_apart: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !out_valid);
endmodule

bind drbg_cmd_seq dseq_checker #(.BLK_W(BLK_W)) u_chk (
  .clk(clk), .rst(rst), .es_req(es_req), .es_ack(es_ack),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_fips(out_fips), .rsp_valid(rsp_valid), .recov_alert(recov_alert),
  .flag0_err_sts(flag0_err_sts)
);

// File: tb/sim_drbg_cmd_seq.sv
`timescale 1ns/1ps
module sim_drbg_cmd_seq;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cmd_valid = 1'b0;
  logic         cmd_ready;
  logic [31:0]  cmd_data = '0;
  logic         es_req;
  logic         es_ack = 1'b0;
  logic         es_fips = 1'b1;
  logic         halt = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [127:0] out_data;
  logic         out_fips;
  logic         rsp_valid, rsp_err, fips, recov_alert, flag0_err_sts;

  always #4 clk = ~clk;

  drbg_cmd_seq u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .es_req(es_req), .es_ack(es_ack), .es_fips(es_fips),
    .halt(halt), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_fips(out_fips), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .fips(fips), .recov_alert(recov_alert),
    .flag0_err_sts(flag0_err_sts)
  );

  int total = 0, bad = 0, cyc = 0, rmode = 0;
  int es_cnt = 0, al_cnt = 0, es_base = 0, al_base = 0;
  bit done_flag = 0;
  bit es_prev = 0;
  logic [127:0] got_q[$], exp_q[$];
  bit gotf_q[$], expf_q[$], rsp_q[$];
  logic [31:0] m_ctr = '0;
  bit m_fips = 0, m_seed = 0, exp_err = 0;
  int exp_es = 0, exp_al = 0;

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // consumer ready pattern, driven away from the sampling point
  initial forever begin
    @(posedge clk); #2;
    cyc++;
    out_ready = (rmode == 0) ? 1'b1 : (rmode == 1) ? (cyc % 3 != 0) : 1'b0;
  end

  // entropy source responder
  initial forever begin
    @(negedge clk);
    if (es_req) begin
      repeat (3) @(negedge clk);
      es_ack = 1'b1;
      @(negedge clk);
      es_ack = 1'b0;
    end
  end

  // monitor, every clock
  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid && out_ready) begin
        got_q.push_back(out_data);
        gotf_q.push_back(out_fips);
      end
      if (rsp_valid) rsp_q.push_back(rsp_err);
      if (es_req && !es_prev) es_cnt++;
      if (recov_alert) al_cnt++;
      es_prev = es_req;
    end
  end

  task automatic send_word(input logic [31:0] w);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_data  = w;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  task automatic send_cmd(input logic [3:0] op, input logic [3:0] cl,
                          input logic [3:0] f0, input logic [12:0] gl,
                          input logic [6:0] rsv);
    exp_err = 0; exp_es = 0; exp_al = 0;
    es_base = es_cnt; al_base = al_cnt;
    if (rsv != 0 || op < 1 || op > 5) exp_err = 1;
    else if (op == 1 || op == 2) begin
      if (f0 == 4'h6) begin m_fips = 0; m_seed = 0; m_ctr = 0; end
      else if (f0 == 4'h9) begin m_fips = 1; m_seed = es_fips; m_ctr = 0; exp_es = 1; end
      else begin exp_err = 1; exp_al = 1; end
    end else if (op == 3) begin
      for (int i = 0; i < gl; i++) begin
        exp_q.push_back({~m_ctr, m_ctr, ~m_ctr, m_ctr});
        expf_q.push_back(m_seed);
        m_ctr = m_ctr + 1;
      end
    end else if (op == 5) begin m_fips = 0; m_seed = 0; m_ctr = 0; end
    send_word({rsv, gl, f0, cl, op});
    for (int i = 0; i < cl; i++) send_word(32'hC0DE_0000 + i);
  endtask

  task automatic finish_cmd(input string tag);
    while (rsp_q.size() == 0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(rsp_q.size() == 1, {tag, " R3 status count"}, rsp_q.size(), 1);
    if (rsp_q.size() > 0) chk(rsp_q[0] == exp_err, {tag, " status"}, rsp_q[0], exp_err);
    chk(got_q.size() == exp_q.size(), {tag, " R2 R3 word count"}, got_q.size(), exp_q.size());
    for (int i = 0; i < got_q.size() && i < exp_q.size(); i++) begin
      chk(got_q[i] == exp_q[i], {tag, " R12 word"}, got_q[i], exp_q[i]);
      chk(gotf_q[i] == expf_q[i], {tag, " R7 word quality"}, gotf_q[i], expf_q[i]);
    end
    chk(fips == m_fips, {tag, " R6 fips"}, fips, m_fips);
    chk(es_cnt - es_base == exp_es, {tag, " R5 entropy requests"}, es_cnt - es_base, exp_es);
    chk(al_cnt - al_base == exp_al, {tag, " R8 alerts"}, al_cnt - al_base, exp_al);
    rsp_q.delete(); got_q.delete(); gotf_q.delete(); exp_q.delete(); expf_q.delete();
  endtask

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk(cmd_ready == 1 && out_valid == 0 && rsp_valid == 0 && es_req == 0, "R1 reset outputs",
        {cmd_ready, out_valid, rsp_valid, es_req}, 4'b1000);
    chk(fips == 0 && recov_alert == 0 && flag0_err_sts == 0, "R1 reset flags",
        {fips, recov_alert, flag0_err_sts}, 0);

    send_cmd(4'd1, 4'd12, 4'h6, 13'd0, 7'd0); finish_cmd("R4 R5 instantiate clen12 flag0 true");
    send_cmd(4'd3, 4'd0, 4'h6, 13'd1, 7'd0);  finish_cmd("R3 generate 1");
    es_fips = 1'b1;
    send_cmd(4'd2, 4'd0, 4'h9, 13'd0, 7'd0);  finish_cmd("R5 R6 reseed flag0 false");
    rmode = 1;
    send_cmd(4'd3, 4'd2, 4'h0, 13'd3, 7'd0);  finish_cmd("R3 R7 generate 3 backpressure");
    rmode = 0;
    send_cmd(4'd3, 4'd0, 4'h0, 13'd0, 7'd0);  finish_cmd("R3 generate 0");
    send_cmd(4'd14, 4'd2, 4'h6, 13'd0, 7'd0); finish_cmd("R11 unknown code");
    send_cmd(4'd3, 4'd0, 4'h0, 13'd1, 7'd1);  finish_cmd("R11 reserved bits");
    send_cmd(4'd3, 4'd0, 4'h0, 13'd1, 7'd0);  finish_cmd("R11 counter kept");
    send_cmd(4'd1, 4'd1, 4'h3, 13'd0, 7'd0);  finish_cmd("R8 bad flag0");
    chk(flag0_err_sts == 1, "R8 sticky status", flag0_err_sts, 1);
    send_cmd(4'd4, 4'd0, 4'h0, 13'd0, 7'd0);  finish_cmd("R13 update");
    send_cmd(4'd3, 4'd0, 4'h0, 13'd1, 7'd0);  finish_cmd("R13 counter kept");
    es_fips = 1'b0;
    send_cmd(4'd1, 4'd0, 4'h9, 13'd0, 7'd0);  finish_cmd("R7 instantiate low quality");
    send_cmd(4'd3, 4'd0, 4'h0, 13'd2, 7'd0);  finish_cmd("R7 generate low quality");

    // R9: halt blocks block requests
    halt = 1'b1;
    send_cmd(4'd3, 4'd0, 4'h0, 13'd2, 7'd0);
    begin
      int hv = 0;
      for (int i = 0; i < 20; i++) begin @(negedge clk); if (out_valid) hv++; end
      chk(hv == 0 && got_q.size() == 0, "R9 no word while halted", hv, 0);
    end
    halt = 1'b0;
    finish_cmd("R9 after halt");

    // R10: word held under stall
    rmode = 2;
    send_cmd(4'd3, 4'd0, 4'h0, 13'd1, 7'd0);
    while (!out_valid) @(negedge clk);
    begin
      logic [127:0] d0;
      d0 = out_data;
      repeat (5) @(negedge clk);
      chk(out_valid == 1 && out_data == d0, "R10 word held", out_data, d0);
    end
    rmode = 0;
    finish_cmd("R10 stall end");

    send_cmd(4'd5, 4'd0, 4'h0, 13'd0, 7'd0);  finish_cmd("R6 uninstantiate");
    send_cmd(4'd3, 4'd0, 4'h0, 13'd1, 7'd0);  finish_cmd("R12 after uninstantiate");

    done_flag = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule